// File: doc/BRIEF.md
# Serial/Parallel Shift Register with Sign Extension

This block is a right-shifting register, eight bits wide by default, whose contents change only on the rising clock edge. Three control levels pick one of four synchronous operations:

- hold the current value;
- load every bit at once from a parallel input bus;
- shift with a fresh serial bit entering at bit 0, taken from one of two serial inputs chosen by a select line;
- a sign-extending shift, in which the end bits keep their values while the interior bits move up by one.

An active-low reset clears the whole register at once, without waiting for the clock, and overrides any clocked operation.

The parallel port is shared between input and output. Here it appears as a separate input bus, an output bus and a drive-enable flag that a pad ring or bus fabric would use. The output drivers are released automatically during a parallel load, and also whenever the active-low output enable is high. A separate serial output always presents the top bit and is never released.

The block is plain control and data. It has no valid/ready handshake, because every input is sampled at each clock edge and there is nothing to stall. The output bus reads zero whenever it is not being driven.

Top module: `sext_shreg`

## Requirements
- R1: While `rst_n` is low, the register is all zeros at once, without any clock edge: `sout` is 0, and `pdata_o` is 0.
- R2: With `reg_en_n` high, a rising edge leaves every bit unchanged, whatever `ser_par`, `fill_ser`, `sin_sel`, `pdata_i` and `oe_n` are.
- R3: With `reg_en_n` low and `ser_par` low, a rising edge loads `pdata_i` into all bits. `sout` then shows the new `pdata_i[W-1]`.
- R4: With `reg_en_n` low, `ser_par` high and `fill_ser` high, a rising edge moves bit n into bit n+1, and bit 0 takes the serial bit. The serial bit is `sin0` when `sin_sel` is 0 and `sin1` when `sin_sel` is 1.
- R5: With `reg_en_n` low, `ser_par` high and `fill_ser` low, a rising edge moves bit n into bit n+1 for n from 0 to W-3. Bit 0 and bit W-1 keep their old values.
- R6: `sout` always equals register bit W-1, and `oe_n` has no effect on it.
- R7: `pdrive` is 1 exactly when `oe_n` is low and (`ser_par` is high or `reg_en_n` is high). `pdata_o` equals the register when `pdrive` is 1 and is zero otherwise.
- R8: `oe_n` high does not stop loads or shifts: the register value seen after `oe_n` returns low reflects every operation done while it was high.
- R9: Starting from any value, W-2 or more consecutive sign-extending shifts leave bits 1 to W-2 all equal to the old bit 0, with bit W-1 unchanged. For W=8, 0x01 becomes 0x7F and 0x81 becomes 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | Register enable, active low; high holds |
| ser_par | input | 1 | 1 selects shifting, 0 selects parallel load |
| fill_ser | input | 1 | In shifting, 1 enters a serial bit and 0 performs a sign-extending shift |
| sin_sel | input | 1 | Serial source select: 0 picks sin0, 1 picks sin1 |
| sin0 | input | 1 | Serial data source 0 |
| sin1 | input | 1 | Serial data source 1 |
| oe_n | input | 1 | Parallel output enable, active low |
| pdata_i | input | W | Parallel load data |
| pdata_o | output | W | Parallel output data, zero when not driven |
| pdrive | output | 1 | Parallel bus drive enable |
| sout | output | 1 | Serial output, register bit W-1 |

## Verification
Random control words cover all eight combinations of enable, serial/parallel and fill mode, with both serial sources and random bus data. This separates hold from load, serial entry from sign extension, and source 0 from source 1, because the two serial inputs are driven with independent values. Directed patterns load values whose end bits differ (0x01, 0x81, 0x80). Running eight sign-extending shifts on them shows whether the end bits are held and whether bit 0 fills the interior. A reset dropped in the middle of a clock low phase shows whether the clear waits for an edge. Loads done while `oe_n` is high, then read back, show whether the output enable leaks into the register path.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_SEXT  = 2'd3
  } sreg_mode_e;
endpackage

// File: rtl/sreg_mode_dec.sv
module sreg_mode_dec
  import sreg_pkg::*;
(
  input  logic       reg_en_n,
  input  logic       ser_par,
  input  logic       fill_ser,
  output sreg_mode_e mode
);
  // Enable high wins; then serial/parallel; then fill selection.
  always_comb begin
    if (reg_en_n)      mode = MODE_HOLD;
    else if (!ser_par) mode = MODE_LOAD;
    else if (fill_ser) mode = MODE_SHIFT;
    else               mode = MODE_SEXT;
  end
endmodule

// File: rtl/sreg_next.sv
module sreg_next
  import sreg_pkg::*;
#(
  parameter int W = 8
) (
  input  sreg_mode_e     mode,
  input  logic [W-1:0]   q,
  input  logic [W-1:0]   pin,
  input  logic           ser_bit,
  output logic [W-1:0]   d
);
  localparam int TOP = W - 1;

  // One next-state mux per bit; the end bits differ in shift sources.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_low
      always_comb begin
        unique case (mode)
          MODE_LOAD:  d[i] = pin[i];
          MODE_SHIFT: d[i] = ser_bit;
          default:    d[i] = q[i];      // hold, sign extend
        endcase
      end
    end else if (i == TOP) begin : g_high
      always_comb begin
        unique case (mode)
          MODE_LOAD:  d[i] = pin[i];
          MODE_SHIFT: d[i] = q[i-1];
          default:    d[i] = q[i];      // hold, sign extend
        endcase
      end
    end else begin : g_mid
      always_comb begin
        unique case (mode)
          MODE_LOAD:  d[i] = pin[i];
          MODE_SHIFT,
          MODE_SEXT:  d[i] = q[i-1];
          default:    d[i] = q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_out_stage.sv
module sreg_out_stage #(
  parameter int W = 8
) (
  input  logic         oe_n,
  input  logic         ser_par,
  input  logic         reg_en_n,
  input  logic [W-1:0] q,
  output logic [W-1:0] pdata_o,
  output logic         pdrive,
  output logic         sout
);
  logic load_cycle;

  // The bus turns around only when a parallel load is actually selected.
  assign load_cycle = !reg_en_n && !ser_par;
  assign pdrive     = !oe_n && !load_cycle;
  assign pdata_o    = pdrive ? q : '0;
  assign sout       = q[W-1];
endmodule

// File: rtl/sext_shreg.sv
module sext_shreg
  import sreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_en_n,
  input  logic         ser_par,
  input  logic         fill_ser,
  input  logic         sin_sel,
  input  logic         sin0,
  input  logic         sin1,
  input  logic         oe_n,
  input  logic [W-1:0] pdata_i,
  output logic [W-1:0] pdata_o,
  output logic         pdrive,
  output logic         sout
);
  sreg_mode_e   mode;
  logic         ser_bit;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  assign ser_bit = sin_sel ? sin1 : sin0;

  sreg_mode_dec u_dec (
    .reg_en_n (reg_en_n),
    .ser_par  (ser_par),
    .fill_ser (fill_ser),
    .mode     (mode)
  );

  sreg_next #(.W(W)) u_next (
    .mode    (mode),
    .q       (q_r),
    .pin     (pdata_i),
    .ser_bit (ser_bit),
    .d       (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  sreg_out_stage #(.W(W)) u_out (
    .oe_n     (oe_n),
    .ser_par  (ser_par),
    .reg_en_n (reg_en_n),
    .q        (q_r),
    .pdata_o  (pdata_o),
    .pdrive   (pdrive),
    .sout     (sout)
  );
endmodule

// File: rtl/sext_shreg_chk.sv
module sext_shreg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_en_n,
  input logic         ser_par,
  input logic         fill_ser,
  input logic         sin_sel,
  input logic         sin0,
  input logic         sin1,
  input logic         oe_n,
  input logic [W-1:0] pdata_i,
  input logic [W-1:0] pdata_o,
  input logic         pdrive,
  input logic         sout,
  input logic [W-1:0] q_r
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (q_r == '0 && !sout && pdata_o == '0));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && reg_en_n) |=> $stable(q_r));

  // R3
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_en_n && !ser_par) |=> (q_r == $past(pdata_i)));

  // R4
  ser_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_en_n && ser_par && fill_ser) |=>
      (q_r[W-1:1] == $past(q_r[W-2:0]) &&
       q_r[0] == ($past(sin_sel) ? $past(sin1) : $past(sin0))));

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_en_n && ser_par && !fill_ser) |=>
      (q_r[W-2:1] == $past(q_r[W-3:0]) &&
       q_r[0] == $past(q_r[0]) && q_r[W-1] == $past(q_r[W-1])));

  // R6
  sout_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sout == q_r[W-1]);

  // R7
  load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en_n && !ser_par) |-> !pdrive);

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!pdrive && pdata_o == '0));

  // R7
  drive_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdrive |-> (pdata_o == q_r));
endmodule

bind sext_shreg sext_shreg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_en_n (reg_en_n),
  .ser_par  (ser_par),
  .fill_ser (fill_ser),
  .sin_sel  (sin_sel),
  .sin0     (sin0),
  .sin1     (sin1),
  .oe_n     (oe_n),
  .pdata_i  (pdata_i),
  .pdata_o  (pdata_o),
  .pdrive   (pdrive),
  .sout     (sout),
  .q_r      (q_r)
);

// File: tb/sext_shreg_bench.sv
`timescale 1ns/1ps
module sext_shreg_bench;
  localparam int W = 8;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en_n = 1'b1, ser_par = 1'b1, fill_ser = 1'b1;
  logic         sin_sel = 1'b0, sin0 = 1'b0, sin1 = 1'b0, oe_n = 1'b0;
  logic [W-1:0] pdata_i = '0;
  logic [W-1:0] pdata_o;
  logic         pdrive, sout;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;   // 125 MHz

  sext_shreg #(.W(W)) u_sext_shreg (
    .clk(clk), .rst_n(rst_n), .reg_en_n(reg_en_n), .ser_par(ser_par),
    .fill_ser(fill_ser), .sin_sel(sin_sel), .sin0(sin0), .sin1(sin1),
    .oe_n(oe_n), .pdata_i(pdata_i), .pdata_o(pdata_o), .pdrive(pdrive),
    .sout(sout)
  );

  function automatic logic [W-1:0] next_val(
      logic [W-1:0] q, logic en_n, logic sp, logic fs,
      logic sel, logic s0, logic s1, logic [W-1:0] pin);
    logic [W-1:0] r;
    r = q;
    if (!en_n) begin
      if (!sp)     r = pin;
      else if (fs) r = {q[W-2:0], (sel ? s1 : s0)};
      else         r[W-2:1] = q[W-3:0];
    end
    return r;
  endfunction

  function automatic string tag_of(logic en_n, logic sp, logic fs);
    if (en_n)    return "R2";
    else if (!sp) return "R3";
    else if (fs) return "R4";
    else         return "R5";
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compares outputs against the model for the inputs now applied.
  task automatic check_outputs(string tag);
    logic drv;
    drv = !oe_n && (ser_par || reg_en_n);
    check("R7 pdrive", {{(W-1){1'b0}}, pdrive}, {{(W-1){1'b0}}, drv});
    check({tag, " state"}, pdata_o, drv ? model : '0);
    check("R6 sout", {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, model[W-1]});
  endtask

  // One clocked operation: drive at negedge, check, then let the edge act.
  task automatic step(logic en_n, logic sp, logic fs, logic sel,
                      logic s0, logic s1, logic oe, logic [W-1:0] pin,
                      string tag);
    @(negedge clk);
    reg_en_n = en_n; ser_par = sp; fill_ser = fs; sin_sel = sel;
    sin0 = s0; sin1 = s1; oe_n = oe; pdata_i = pin;
    #1 check_outputs(tag);
    @(posedge clk);
    model = next_val(model, en_n, sp, fs, sel, s0, s1, pin);
  endtask

  // Read back through a driven hold cycle.
  task automatic peek(string tag, logic [W-1:0] exp);
    @(negedge clk);
    reg_en_n = 1'b1; oe_n = 1'b0;
    #1 check(tag, pdata_o, exp);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 check("R1 reset", pdata_o, '0);
    check("R1 sout", {{(W-1){1'b0}}, sout}, '0);
    rst_n = 1'b1;

    // R3: load, then both serial sources R4
    step(0, 0, 1, 0, 0, 0, 0, 8'hA5, "R3");
    peek("R3 load A5", 8'hA5);
    step(0, 1, 1, 0, 1, 0, 0, '0, "R4");
    peek("R4 sin0", 8'h4B);
    step(0, 1, 1, 1, 1, 0, 0, '0, "R4");
    peek("R4 sin1", 8'h96);

    // R9 / R5: eight sign-extending shifts from three seeds
    step(0, 0, 1, 0, 0, 0, 0, 8'h01, "R3");
    for (int k = 0; k < 8; k++) step(0, 1, 0, 0, 1, 1, 0, '0, "R5");
    peek("R9 01->7F", 8'h7F);
    step(0, 0, 1, 0, 0, 0, 0, 8'h81, "R3");
    for (int k = 0; k < 8; k++) step(0, 1, 0, 1, 0, 0, 0, '0, "R5");
    peek("R9 81->FF", 8'hFF);
    step(0, 0, 1, 0, 0, 0, 0, 8'h80, "R3");
    for (int k = 0; k < 8; k++) step(0, 1, 0, 0, 0, 0, 0, '0, "R5");
    peek("R9 80->80", 8'h80);

    // R8: operations with outputs released
    step(0, 0, 1, 0, 0, 0, 1, 8'h3C, "R8");
    step(0, 1, 1, 1, 0, 1, 1, '0, "R8");
    peek("R8 oe high ops", 8'h79);

    // R2: hold ignores every other input
    step(1, 0, 0, 1, 1, 1, 1, 8'hFF, "R2");
    peek("R2 hold", 8'h79);

    // R1: reset dropped mid low phase clears without an edge
    @(negedge clk);
    reg_en_n = 1'b1; oe_n = 1'b0;
    #2 rst_n = 1'b0;
    #1 check("R1 async clear", pdata_o, '0);
    check("R1 async sout", {{(W-1){1'b0}}, sout}, '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // Random mix over all control combinations
    for (int n = 0; n < 600; n++) begin
      logic en_n, sp, fs, sel, s0, s1, oe;
      logic [W-1:0] pin;
      en_n = ($urandom % 4) == 0;
      sp = ($urandom % 3) != 0;
      fs = $urandom % 2; sel = $urandom % 2;
      s0 = $urandom % 2; s1 = $urandom % 2;
      oe = ($urandom % 5) == 0;
      pin = W'($urandom);
      step(en_n, sp, fs, sel, s0, s1, oe, pin, tag_of(en_n, sp, fs));
    end
    peek("R2 final", model);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule